// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a 32-bit processor core whose interrupt and exception handlers run in their own processor modes. Software sees sixteen registers, with index 13 as the stack pointer, 14 as the link register and 15 as the program counter. The physical storage behind an index depends on the current mode. Handlers therefore find private copies of the registers they clobber first, and need no save and restore sequence.

The block holds the current mode in a register that resets to supervisor. The mode changes through a mode write port, or through an exception entry. An exception entry moves the core into the target mode and copies the incoming status word into that mode's saved-status register, both in one clock. There are two combinational read ports and one synchronous write port. The program counter also has a dedicated load port. A saved-status port reads and writes the saved-status register of the current mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode output is 10011 (supervisor), and every register and every saved-status register reads zero.
- R2: Indices 0 to 7 and index 15 address a single physical register that every mode shares.
- R3: In mode 10001 (fast interrupt), indices 8 to 14 address seven registers that no other mode can reach.
- R4: Modes 10010 (interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) each have private registers at indices 13 and 14. In these modes, indices 8 to 12 address the same five registers as user mode.
- R5: Mode 11111 (system) uses exactly the registers of mode 10000 (user). Every mode code not listed in R3, R4 or R5 behaves as user mode for register selection and saved-status access.
- R6: A register write takes effect at the rising clock edge. A read of the same physical register in the same cycle returns the value from before the write.
- R7: Asserting pc_ld loads pc_ld_data into the index-15 register. When pc_ld and a write to index 15 happen in the same cycle, the pc_ld value wins.
- R8: An exception entry whose target is one of the five exception modes of R3 and R4 does two things at the next edge: it sets the mode to the target, and it copies status_i into the target's saved-status register. An entry with any other target code changes nothing.
- R9: In an exception mode, sst_rdata shows that mode's saved-status register, and sst_we writes it. In user-behaving modes, sst_rdata is zero and sst_we is ignored.
- R10: mode_we loads mode_wdata into the mode register, and mode_o shows the stored code. A valid exception entry in the same cycle takes priority over mode_we. In that cycle it also takes priority over an sst_we aimed at the same saved-status register.
- R11: Register writes, saved-status writes and read selection all use the mode held before the clock edge, not the mode being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Load mode_wdata into the mode register |
| mode_wdata | input | 5 | New mode code |
| mode_o | output | 5 | Current mode code |
| exc_entry | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode entered on exception |
| status_i | input | 32 | Current status word, captured on entry |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| pc_ld | input | 1 | Program-counter load strobe |
| pc_ld_data | input | 32 | Program-counter load value |
| sst_we | input | 1 | Saved-status write enable for the current mode |
| sst_wdata | input | 32 | Saved-status write data |
| sst_rdata | output | 32 | Saved-status register of the current mode |

## Verification
The assertions assume that every control input is a known 0 or 1 once reset is released. They also assume that the indices and mode codes are never X. They accept any combination of strobes in one cycle, including entry, mode write, register write, program-counter load and saved-status write together. The bench drives every input to a defined value on each falling edge. It draws mode codes mostly from the seven defined encodings and sometimes from the whole 5-bit range. It raises the strobes independently, so that collisions between them occur often.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int MODE_W   = 5;
    localparam int IDX_W    = 4;
    localparam int NUM_VIS  = 1 << IDX_W;
    localparam int PC_IDX   = NUM_VIS - 1;
    localparam int LO_SHARED = 8;
    localparam int FIQ_FIRST = 8;
    localparam int PAIR_FIRST = 13;
    localparam int FIQ_CNT  = PC_IDX - FIQ_FIRST;
    localparam int NUM_EXC  = 5;
    localparam int FIQ_BASE = NUM_VIS;
    localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;
    localparam int NUM_PHYS = PAIR_BASE + 2 * (NUM_EXC - 1);
    localparam int PHYS_W   = $clog2(NUM_PHYS);

    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;
endpackage

// File: rtl/brf_mode_dec.sv
module brf_mode_dec
    import brf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              is_exc
);
    always_comb begin
        unique case (mode)
            M_FIQ:   bank = BK_FIQ;
            M_IRQ:   bank = BK_IRQ;
            M_SVC:   bank = BK_SVC;
            M_ABT:   bank = BK_ABT;
            M_UND:   bank = BK_UND;
            default: bank = BK_USR;
        endcase
        is_exc = (bank != BK_USR);
    end
endmodule

// File: rtl/brf_idx_map.sv
module brf_idx_map
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] idx_w;
    logic [PHYS_W-1:0] pair_base;

    always_comb begin
        idx_w = PHYS_W'(idx);
        if (bank == BK_USR) pair_base = PHYS_W'(PAIR_FIRST);
        else pair_base = PHYS_W'(PAIR_BASE) + PHYS_W'(2 * (int'(bank) - 2));

        if (idx == IDX_W'(PC_IDX) || idx < IDX_W'(LO_SHARED))
            phys = idx_w;
        else if (bank == BK_FIQ)
            phys = PHYS_W'(FIQ_BASE) + idx_w - PHYS_W'(FIQ_FIRST);
        else if (idx < IDX_W'(PAIR_FIRST))
            phys = idx_w;
        else
            phys = pair_base + idx_w - PHYS_W'(PAIR_FIRST);
    end

    // R2: low indices and PC never leave the shared slots
    a_r2_shared_low: assert property (@(posedge clk) disable iff (!rst_n)
        (idx < IDX_W'(LO_SHARED) || idx == IDX_W'(PC_IDX)) |-> phys == idx_w);
    // R3: fast-interrupt high indices land in its private bank
    a_r3_fiq_private: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BK_FIQ && idx >= IDX_W'(FIQ_FIRST) && idx != IDX_W'(PC_IDX))
        |-> (phys >= PHYS_W'(FIQ_BASE) && phys < PHYS_W'(PAIR_BASE)));
    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phys < PHYS_W'(NUM_PHYS));
endmodule

// File: rtl/brf_saved_status.sv
module brf_saved_status
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             cur_bank,
    input  logic              entry_vld,
    input  bank_e             entry_bank,
    input  logic [DATA_W-1:0] status_i,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [NUM_EXC-1:0][DATA_W-1:0] sst;
    } sst_state_t;

    sst_state_t state_d, state_q;

    function automatic int slot_of(bank_e b);
        return int'(b) - 1;
    endfunction

    always_comb begin
        state_d = state_q;
        if (we && cur_bank != BK_USR)
            state_d.sst[slot_of(cur_bank)] = wdata;
        if (entry_vld)
            state_d.sst[slot_of(entry_bank)] = status_i;
        rdata = (cur_bank == BK_USR) ? '0 : state_q.sst[slot_of(cur_bank)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R8: entry captures the status word into the target's slot
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && entry_bank != BK_USR)
        |=> state_q.sst[slot_of($past(entry_bank))] == $past(status_i));
    // R9: user-behaving modes leave saved status untouched
    a_r9_user_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank == BK_USR && !entry_vld) |=> $stable(state_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [4:0]        mode_wdata,
    output logic [4:0]        mode_o,
    input  logic              exc_entry,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] status_i,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_ld,
    input  logic [DATA_W-1:0] pc_ld_data,
    input  logic              sst_we,
    input  logic [DATA_W-1:0] sst_wdata,
    output logic [DATA_W-1:0] sst_rdata
);
    typedef struct packed {
        logic [MODE_W-1:0]               mode;
        logic [NUM_PHYS-1:0][DATA_W-1:0] rf;
    } rf_state_t;

    rf_state_t state_d, state_q;

    bank_e             cur_bank, exc_bank;
    logic              cur_is_exc, exc_is_exc;
    logic              entry_vld;
    logic [PHYS_W-1:0] phys_a, phys_b, phys_w;

    brf_mode_dec u_dec_cur (.mode(state_q.mode), .bank(cur_bank), .is_exc(cur_is_exc));
    brf_mode_dec u_dec_exc (.mode(exc_mode),     .bank(exc_bank), .is_exc(exc_is_exc));

    assign entry_vld = exc_entry && exc_is_exc;

    brf_idx_map u_map_a (.clk(clk), .rst_n(rst_n), .bank(cur_bank), .idx(rd_a_idx), .phys(phys_a));
    brf_idx_map u_map_b (.clk(clk), .rst_n(rst_n), .bank(cur_bank), .idx(rd_b_idx), .phys(phys_b));
    brf_idx_map u_map_w (.clk(clk), .rst_n(rst_n), .bank(cur_bank), .idx(wr_idx),   .phys(phys_w));

    brf_saved_status #(.DATA_W(DATA_W)) u_sst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_bank  (cur_bank),
        .entry_vld (entry_vld),
        .entry_bank(exc_bank),
        .status_i  (status_i),
        .we        (sst_we),
        .wdata     (sst_wdata),
        .rdata     (sst_rdata)
    );

    always_comb begin
        state_d = state_q;
        if (entry_vld)    state_d.mode = exc_mode;
        else if (mode_we) state_d.mode = mode_wdata;
        if (wr_en)        state_d.rf[phys_w] = wr_data;
        if (pc_ld)        state_d.rf[PC_IDX] = pc_ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mode <= M_SVC;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_a_data = state_q.rf[phys_a];
    assign rd_b_data = state_q.rf[phys_b];
    assign mode_o    = state_q.mode;

    // R7: the load port always decides the program counter
    a_r7_pc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |=> state_q.rf[PC_IDX] == $past(pc_ld_data));
    // R6: a plain write lands in the mapped slot at the edge
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(pc_ld && phys_w == PHYS_W'(PC_IDX)))
        |=> state_q.rf[$past(phys_w)] == $past(wr_data));
    // R10: valid entry beats a mode write
    a_r10_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
        entry_vld |=> state_q.mode == $past(exc_mode));
    // R8: an entry to a non-exception code leaves the mode alone without mode_we
    a_r8_bad_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_vld && !mode_we) |=> $stable(state_q.mode));
endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [4:0]  mode_wdata = '0;
    logic [4:0]  mode_o;
    logic        exc_entry = 1'b0;
    logic [4:0]  exc_mode = '0;
    logic [31:0] status_i = '0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, sst_rdata;
    logic        wr_en = 1'b0, pc_ld = 1'b0, sst_we = 1'b0;
    logic [31:0] wr_data = '0, pc_ld_data = '0, sst_wdata = '0;

    always #2 clk = ~clk;

    banked_regfile dut (.*);

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] m_rf [31];
    logic [31:0] m_sst [5];
    logic [4:0]  m_mode;

    localparam logic [4:0] CODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111};

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int slot_of(logic [4:0] m, logic [3:0] i);
        int b = bank_of(m);
        if (i == 15 || i < 8) return i;
        if (b == 1) return 16 + i - 8;
        if (i < 13) return i;
        if (b == 0) return i;
        return 23 + 2 * (b - 2) + (i - 13);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        check({req, " rdA"}, rd_a_data, m_rf[slot_of(m_mode, rd_a_idx)]);
        check({req, " rdB"}, rd_b_data, m_rf[slot_of(m_mode, rd_b_idx)]);
        check({req, " mode"}, {27'd0, mode_o}, {27'd0, m_mode});
        check({req, " sst"}, sst_rdata,
              bank_of(m_mode) == 0 ? 32'd0 : m_sst[bank_of(m_mode) - 1]);
    endtask

    task automatic model_edge();
        int ob = bank_of(m_mode);
        bit ev = exc_entry && bank_of(exc_mode) != 0;
        if (wr_en) m_rf[slot_of(m_mode, wr_idx)] = wr_data;
        if (pc_ld) m_rf[15] = pc_ld_data;
        if (sst_we && ob != 0) m_sst[ob - 1] = sst_wdata;
        if (ev) m_sst[bank_of(exc_mode) - 1] = status_i;
        if (ev) m_mode = exc_mode;
        else if (mode_we) m_mode = mode_wdata;
    endtask

    task automatic idle();
        mode_we = 0; exc_entry = 0; wr_en = 0; pc_ld = 0; sst_we = 0;
    endtask

    task automatic step(string req);
        #1; check_outputs(req);
        @(posedge clk); model_edge();
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 31; i++) m_rf[i] = '0;
        for (int i = 0; i < 5; i++) m_sst[i] = '0;
        m_mode = 5'b10011;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_a_idx = 13; rd_b_idx = 15;
        #1;
        check("R1 mode", {27'd0, mode_o}, 32'h13);
        check("R1 sst", sst_rdata, 0);
        check("R1 sp", rd_a_data, 0);
        check("R1 pc", rd_b_data, 0);
        @(negedge clk);

        // R6 same-cycle read sees old value
        wr_en = 1; wr_idx = 3; wr_data = 32'hAAAA_0003; rd_a_idx = 3;
        #1; check("R6 old value", rd_a_data, 0);
        @(posedge clk); model_edge(); @(negedge clk); idle();
        #1; check("R6 new value", rd_a_data, 32'hAAAA_0003);

        // R7 pc load wins over write to index 15
        wr_en = 1; wr_idx = 15; wr_data = 32'h1111; pc_ld = 1; pc_ld_data = 32'h2222;
        step("R7"); idle(); rd_b_idx = 15;
        #1; check("R7 pc priority", rd_b_data, 32'h2222);

        // R4 supervisor-private SP, then R5 user and unknown code share SP
        wr_en = 1; wr_idx = 13; wr_data = 32'h5555_0013; step("R4"); idle();
        mode_we = 1; mode_wdata = 5'b10000; step("R5"); idle();
        rd_a_idx = 13; #1; check("R4 user sp differs", rd_a_data, 0);
        wr_en = 1; wr_idx = 13; wr_data = 32'h0bad_0013; step("R5"); idle();
        mode_we = 1; mode_wdata = 5'b00101; step("R5"); idle();
        #1; check("R5 unknown as user", rd_a_data, 32'h0bad_0013);
        check("R9 unknown sst zero", sst_rdata, 0);

        // R8 entry with invalid target is ignored; R9 user sst write ignored
        exc_entry = 1; exc_mode = 5'b11111; status_i = 32'hdead; sst_we = 1; sst_wdata = 32'hbeef;
        step("R8"); idle();
        #1; check("R8 bad entry mode", {27'd0, mode_o}, 32'h05);
        check("R9 user sst write ignored", sst_rdata, 0);

        // R8/R10 valid entry to FIQ beats mode write
        exc_entry = 1; exc_mode = 5'b10001; status_i = 32'h600D_F1F0;
        mode_we = 1; mode_wdata = 5'b10010; step("R10"); idle();
        #1; check("R10 entry wins", {27'd0, mode_o}, 32'h11);
        check("R8 captured", sst_rdata, 32'h600D_F1F0);
        // R3 FIQ r8 private
        wr_en = 1; wr_idx = 8; wr_data = 32'hF1F0_0008; step("R3"); idle();
        mode_we = 1; mode_wdata = 5'b11111; step("R5"); idle();
        rd_a_idx = 8; #1; check("R3 sys r8 unaffected", rd_a_data, 0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] mc;
            mc = ($urandom % 8 == 0) ? 5'($urandom) : CODES[$urandom % 7];
            mode_we    = ($urandom % 6 == 0);
            mode_wdata = mc;
            exc_entry  = ($urandom % 8 == 0);
            exc_mode   = ($urandom % 5 == 0) ? 5'($urandom) : CODES[$urandom % 7];
            status_i   = $urandom;
            rd_a_idx   = 4'($urandom); rd_b_idx = 4'($urandom);
            wr_en      = ($urandom % 2 == 0); wr_idx = 4'($urandom); wr_data = $urandom;
            pc_ld      = ($urandom % 10 == 0); pc_ld_data = $urandom;
            sst_we     = ($urandom % 5 == 0); sst_wdata = $urandom;
            step("R2 R3 R4 R11 random");
        end
        idle();
        #1; check_outputs("R11 final");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule